// File: doc/BRIEF.md
# DMX512 Universe Frame Transmitter

This block sends one whole lighting-control packet on a single serial line each time it is started. A packet opens with a break, in which the line is held low, and then a mark-after-break, in which the line is held high. In both phases the sequencer drives the pin directly and the byte shifter stays idle. A fixed number of asynchronous byte slots follows. The first slots are taken in index order from a small channel buffer. Every later slot carries zero, so the total slot count on the wire is the same however many channels are stored.

The serial format is 8 data bits, no parity and two stop bits. The bit time is a parameter in clock cycles, and so are the break and mark lengths. The defaults give 250 kbaud, an 88 µs break and an 8 µs mark at 16 MHz. Slots follow one another with no idle gap. Software or a neighbouring block fills the buffer through a write port of the valid/ready kind. `wr_ready` is always high, so a write is taken in the same cycle that `wr_valid` is high, and it may arrive at any time, including during a packet. The buffer is read at the moment a slot is loaded into the shifter, and that slot's byte is latched, so a later write cannot change it.

Top module: `dmx_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, `tx` is 1, `busy` is 0 and `done` is 0.
- R2: A `start` pulse while idle sets `busy` from the next cycle, and `tx` is then 0 for exactly BREAK_CYCLES cycles.
- R3: After the break, `tx` is 1 for exactly MAB_CYCLES cycles, and the start bit of slot 0 comes in the very next cycle.
- R4: Each slot lasts 11 bit times of BIT_CYCLES cycles each: a start bit at 0, data bits 0 to 7 with the least significant bit first, then two stop bits at 1.
- R5: Slots 0 to NUM_CHAN-1 carry buffer entries 0 to NUM_CHAN-1 in ascending order.
- R6: Slots NUM_CHAN to NUM_SLOTS-1 carry 0x00, and exactly NUM_SLOTS slots are sent.
- R7: Slots are back to back: the first stop bit of one slot ends, and after the second stop bit the next slot's start bit begins with no idle cycle.
- R8: A `start` pulse while `busy` is 1 is ignored. The packet in progress goes on unchanged and no extra packet follows.
- R9: `done` is 1 for exactly one cycle, the one right after the last stop bit of the final slot. `busy` is 0 from the following cycle, and `tx` stays 1.
- R10: A buffer write in a packet changes a later slot of that packet if that slot has not yet been loaded. It never changes a slot that is already being shifted out.
- R11: `wr_ready` is always 1, and a write with `wr_valid` at 1 stores `wr_data` at `wr_addr` in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to send a packet |
| busy | output | 1 | High while a packet is in progress |
| done | output | 1 | One-cycle pulse when a packet completes |
| wr_valid | input | 1 | Buffer write request |
| wr_ready | output | 1 | Buffer write accepted (always 1) |
| wr_addr | input | $clog2(NUM_CHAN) | Buffer entry index |
| wr_data | input | 8 | Byte to store |
| tx | output | 1 | Serial output line |

## Verification
The assertions check these rules on every cycle:
- a `start` during a packet never ends it early;
- `done` is a single-cycle pulse, and `tx` is high while it is asserted;
- both stop bits are high;
- the shift register does not change inside a bit time;
- the slot counter never goes past NUM_SLOTS.

Other behaviour depends on what the bench feeds in, so only its reference model, compared with the outputs every clock, can show it:
- the exact lengths of the break and the mark;
- the bit order, and the buffer order within a slot;
- the zero padding;
- that a write lands in a later slot and never in the slot on the wire;
- that a `start` given in the cycle after `done` begins a fresh packet.

// File: rtl/dmx_tx_pkg.sv
package dmx_tx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BREAK = 2'd1,
    PH_MARK  = 2'd2,
    PH_SLOTS = 2'd3
  } phase_t;
endpackage

// File: rtl/dmx_chan_buf.sv
module dmx_chan_buf #(
  parameter int NUM_CHAN = 32,
  parameter int DATA_W   = 8,
  localparam int AW      = $clog2(NUM_CHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] entry [NUM_CHAN];

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry[i] <= '0;
      else if (we && waddr == AW'(i))
        entry[i] <= wdata;
    end
  end

  assign rdata = entry[raddr];
endmodule

// File: rtl/dmx_byte_shifter.sv
module dmx_byte_shifter #(
  parameter int BIT_CYCLES = 64,
  parameter int DATA_W     = 8,
  parameter int STOP_BITS  = 2,
  localparam int FRAME_W   = 1 + DATA_W + STOP_BITS,
  localparam int BC_W      = $clog2(BIT_CYCLES),
  localparam int IDX_W     = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  output logic              ld_ready,
  output logic              active,
  output logic              line
);
  logic [FRAME_W-1:0] shreg;
  logic [BC_W-1:0]    bit_cnt;
  logic [IDX_W-1:0]   bit_idx;
  logic               bit_end;
  logic               frame_end;

  assign bit_end   = active && (bit_cnt == BC_W'(BIT_CYCLES - 1));
  assign frame_end = bit_end && (bit_idx == IDX_W'(FRAME_W - 1));
  assign ld_ready  = !active || frame_end;
  assign line      = active ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      shreg   <= '1;
      bit_cnt <= '0;
      bit_idx <= '0;
    end else if (ld_valid && ld_ready) begin
      active  <= 1'b1;
      shreg   <= {{STOP_BITS{1'b1}}, ld_data, 1'b0};
      bit_cnt <= '0;
      bit_idx <= '0;
    end else if (active) begin
      if (bit_end) begin
        bit_cnt <= '0;
        if (frame_end) begin
          active <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          shreg   <= {1'b1, shreg[FRAME_W-1:1]};
        end
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_idx >= IDX_W'(1 + DATA_W)) |-> line); // R4

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bit_end) |=> $stable(shreg)); // R10
endmodule

// File: rtl/dmx_sequencer.sv
module dmx_sequencer
  import dmx_tx_pkg::*;
#(
  parameter int BREAK_CYCLES = 1408,
  parameter int MAB_CYCLES   = 128,
  parameter int NUM_CHAN     = 32,
  parameter int NUM_SLOTS    = 258,
  parameter int DATA_W       = 8,
  localparam int AW          = $clog2(NUM_CHAN),
  localparam int CNT_MAX     = (BREAK_CYCLES > MAB_CYCLES) ? BREAK_CYCLES : MAB_CYCLES,
  localparam int CNT_W       = $clog2(CNT_MAX),
  localparam int SL_W        = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  input  logic              ld_ready,
  input  logic              sh_active,
  output logic              frc_en,
  output logic              frc_val
);
  phase_t          phase;
  logic [CNT_W-1:0] cnt;
  logic [SL_W-1:0]  slot;
  logic             brk_last;
  logic             mab_last;
  logic             all_loaded;

  assign brk_last   = (phase == PH_BREAK) && (cnt == CNT_W'(BREAK_CYCLES - 1));
  assign mab_last   = (phase == PH_MARK)  && (cnt == CNT_W'(MAB_CYCLES - 1));
  assign all_loaded = (slot == SL_W'(NUM_SLOTS));
  assign ld_valid   = mab_last || ((phase == PH_SLOTS) && !all_loaded);
  assign rd_addr    = slot[AW-1:0];
  assign ld_data    = (slot < SL_W'(NUM_CHAN)) ? rd_data : '0;
  assign done       = (phase == PH_SLOTS) && all_loaded && !sh_active;
  assign busy       = (phase != PH_IDLE);
  assign frc_en     = (phase == PH_BREAK) || (phase == PH_MARK);
  assign frc_val    = (phase == PH_MARK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      slot  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_BREAK;
          cnt   <= '0;
          slot  <= '0;
        end
        PH_BREAK: begin
          cnt <= cnt + 1'b1;
          if (brk_last) begin
            phase <= PH_MARK;
            cnt   <= '0;
          end
        end
        PH_MARK: begin
          cnt <= cnt + 1'b1;
          if (mab_last) begin
            phase <= PH_SLOTS;
            cnt   <= '0;
          end
        end
        PH_SLOTS: if (done) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
      if (ld_valid && ld_ready)
        slot <= slot + 1'b1;
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SL_W'(NUM_SLOTS)); // R6
endmodule

// File: rtl/dmx_tx.sv
module dmx_tx #(
  parameter int BIT_CYCLES   = 64,
  parameter int BREAK_CYCLES = 1408,
  parameter int MAB_CYCLES   = 128,
  parameter int NUM_CHAN     = 32,
  parameter int NUM_SLOTS    = 258,
  localparam int DATA_W      = 8,
  localparam int STOP_BITS   = 2,
  localparam int AW          = $clog2(NUM_CHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx
);
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              ld_valid;
  logic [DATA_W-1:0] ld_data;
  logic              ld_ready;
  logic              sh_active;
  logic              sh_line;
  logic              frc_en;
  logic              frc_val;

  assign wr_ready = 1'b1;
  assign tx       = frc_en ? frc_val : sh_line;

  dmx_chan_buf #(.NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(wr_valid && wr_ready),
    .waddr(wr_addr), .wdata(wr_data), .raddr(rd_addr), .rdata(rd_data)
  );

  dmx_sequencer #(
    .BREAK_CYCLES(BREAK_CYCLES), .MAB_CYCLES(MAB_CYCLES),
    .NUM_CHAN(NUM_CHAN), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data), .ld_valid(ld_valid),
    .ld_data(ld_data), .ld_ready(ld_ready), .sh_active(sh_active),
    .frc_en(frc_en), .frc_val(frc_val)
  );

  dmx_byte_shifter #(
    .BIT_CYCLES(BIT_CYCLES), .DATA_W(DATA_W), .STOP_BITS(STOP_BITS)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_ready(ld_ready), .active(sh_active), .line(sh_line)
  );

  AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tx); // R9
endmodule

// File: tb/sim_dmx_tx.sv
module sim_dmx_tx;
  localparam int T   = 4;
  localparam int B   = 40;
  localparam int M   = 12;
  localparam int NCH = 8;
  localparam int S   = 20;
  localparam int SL  = 11 * T;
  localparam int ENDC = B + M + S * SL;
  localparam int AW  = $clog2(NCH);

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic wr_valid = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy, done, wr_ready, tx;

  int n_chk = 0;
  int n_fail = 0;
  int n_done = 0;
  int cyc = 0;

  dmx_tx #(.BIT_CYCLES(T), .BREAK_CYCLES(B), .MAB_CYCLES(M),
           .NUM_CHAN(NCH), .NUM_SLOTS(S)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx(tx)
  );

  always #5 clk = ~clk;

  // reference model
  logic [7:0] m_mem [NCH];
  logic [7:0] m_byte [S];
  bit m_busy = 0;
  int off = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0;
      off = 0;
      for (int i = 0; i < NCH; i++) m_mem[i] = 8'h00;
    end else begin
      if (m_busy) begin
        if (off >= B + M && (off - B - M) % SL == 0 && (off - B - M) / SL < S) begin
          int k;
          k = (off - B - M) / SL;
          m_byte[k] = (k < NCH) ? m_mem[k] : 8'h00;
        end
        if (off == ENDC + 1) m_busy = 0;
        else off++;
      end else if (start) begin
        m_busy = 1;
        off = 1;
      end
      if (wr_valid) m_mem[wr_addr] = wr_data;
    end
  end

  function automatic string tag_of();
    if (!m_busy) return "R1";
    if (off <= B) return "R2";
    if (off <= B + M) return "R3";
    if (off <= ENDC) begin
      if ((off - B - M - 1) / SL < NCH) return "R4 R5 R7 R10";
      return "R4 R6 R7";
    end
    return "R9";
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int e_tx, e_busy, e_done;
      e_busy = m_busy ? 1 : 0;
      e_done = (m_busy && off == ENDC + 1) ? 1 : 0;
      if (!m_busy || off > ENDC) e_tx = 1;
      else if (off <= B) e_tx = 0;
      else if (off <= B + M) e_tx = 1;
      else begin
        int r, k, b;
        r = off - B - M - 1;
        k = r / SL;
        b = (r % SL) / T;
        if (b == 0) e_tx = 0;
        else if (b <= 8) e_tx = int'(m_byte[k][b-1]);
        else e_tx = 1;
      end
      chk(tag_of(), "tx", int'(tx), e_tx);
      chk(m_busy && off > 1 && off <= B ? "R2" : (m_busy ? "R8" : "R1"), "busy", int'(busy), e_busy);
      chk("R9", "done", int'(done), e_done);
      chk("R11", "wr_ready", int'(wr_ready), 1);
      if (done) n_done++;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_valid = 1; wr_addr = AW'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic finish_run();
    chk("R8", "done pulse count", n_done, 3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", "reset tx", int'(tx), 1);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset done", int'(done), 0);
    // packet 1: distinct bit patterns
    wr(0, 8'h01); wr(1, 8'h80); wr(2, 8'hA5); wr(3, 8'h5A);
    wr(4, 8'hFF); wr(5, 8'h00); wr(6, 8'h3C); wr(7, 8'hC3);
    pulse_start();
    wait_done();
    repeat (5) @(negedge clk);
    // packet 2: ignored starts (R8) and in-flight writes (R10)
    pulse_start();
    repeat (10) @(negedge clk);
    start = 1; @(negedge clk) start = 0;
    repeat (48) @(negedge clk);
    wr(0, 8'h77);
    wr(5, 8'h99);
    repeat (300) @(negedge clk);
    start = 1; @(negedge clk) start = 0;
    wait_done();
    // packet 3: start in the cycle right after done
    pulse_start();
    wait_done();
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    #(20000 * 10);
    n_fail++;
    $display("FAIL R9 watchdog expired: actual 0 expected 1 completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule